// File: doc/BRIEF.md
# Contactless Tag Page Memory Controller

This block is the memory engine inside a small contactless tag whose storage is organised as sixteen pages of four bytes. The radio front end, framing, CRC handling and anticollision sit elsewhere; this block only sees command frames that have already been decoded into a stream of bytes: an opcode byte, a page address byte, and as many data bytes as the opcode calls for. It executes the command against its internal 64-byte store. It then answers either with a stream of read bytes or with a single byte that carries a 4-bit acknowledge code.

The store carries protection rules. The two identifier pages can never be written. The configuration page, page 2, only accumulates lock bits. Page 3 is one-time programmable, so its bits can only be set. Each page from 4 to 15 can be frozen by a lock bit held in page 2. A read returns four consecutive pages and wraps around the page space. A legacy 16-byte write form is accepted and stores only its first four data bytes.

The power-on image comes from a parameter. A preload port can overwrite any page directly, for example to load a personalisation image, and it bypasses every protection rule.

Top module: `tag_page_engine`

## Requirements
- R1: After reset the store holds the INIT_IMAGE parameter, with page p in bits [32p+31:32p]. `in_ready` is 1 and `out_valid` is 0.
- R2: Opcode 0x30 followed by address a (0..15) returns 16 bytes. They come from pages a, a+1, a+2 and a+3 in that order. Within each page, byte k is bits [8k+7:8k], and byte 0 is sent first. `out_ack` is 0 on every read byte, and `out_last` is 1 on the 16th byte only.
- R3: Read page addressing wraps modulo 16, so start address 0x0E returns pages 14, 15, 0 and 1.
- R4: Any command with an address above 0x0F is answered with a negative acknowledge and leaves the store unchanged. A write still consumes all of its data bytes before the answer. A negative acknowledge is one byte with `out_ack`=1, `out_last`=1 and code 0x0 in bits [3:0].
- R5: Opcode 0xA2 with 4 data bytes replaces an unlocked page in 4..15 with those bytes and answers with acknowledge code 0xA. Data byte k lands in bits [8k+7:8k].
- R6: Opcode 0xA0 takes 16 data bytes and stores only the first four, in the same way as R5. It answers once, after the 16th byte.
- R7: A write to page 0 or 1 is answered with a negative acknowledge, and the page is unchanged.
- R8: A write to page 3 ORs the data into the page, so a bit at 1 never returns to 0 through a write.
- R9: A write to page 2 leaves bytes 0 and 1 unchanged and ORs data bytes 2 and 3 into bytes 2 and 3, then answers with an acknowledge. Bit n of page 2 bits [31:16] locks page n, for n from 4 to 15. A lock bit can only be cleared by reset or by the preload port.
- R10: A write to a locked page is answered with a negative acknowledge, and the page is unchanged.
- R11: An opcode other than 0x30, 0xA0 and 0xA2 is answered with a negative acknowledge right after the opcode byte. The next input byte is then taken as a new opcode.
- R12: A cycle with `pl_en`=1 writes `pl_word` into page `pl_page` on that clock edge, whatever the lock, identifier and one-time rules say.
- R13: `in_ready` and `out_valid` are never 1 together. While `out_valid` is 1 and `out_ready` is 0, the output byte and its flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Block accepts a command byte |
| in_byte | input | 8 | Command byte (opcode, address, data) |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Receiver accepts the response byte |
| out_byte | output | 8 | Response byte; acknowledge code in bits [3:0] |
| out_ack | output | 1 | Response byte is an acknowledge code |
| out_last | output | 1 | Final byte of the response |
| pl_en | input | 1 | Preload write strobe |
| pl_page | input | 4 | Preload page index |
| pl_word | input | 32 | Preload page contents |

## Verification
The protection assertions treat any cycle with `pl_en` high as an allowed exception. They therefore only claim that command writes never lower a one-time bit, never clear a lock and never alter an identifier or locked page. The response-hold property assumes the preload port does not rewrite a page while that page is being streamed out. The stimulus guarantees this by driving preloads only between complete commands. Random commands mix legal and illegal addresses, every opcode kind and random output back-pressure. Most page-2 writes carry zero lock bytes, so that most lockable pages stay writable for the rest of the run.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
    localparam int PAGE_W         = 32;
    localparam int BYTE_W         = 8;
    localparam int LOCK_PAGE      = 2;
    localparam int OTP_PAGE       = 3;
    localparam int FIRST_WRITABLE = 2;
    localparam int FIRST_LOCKABLE = 4;
    localparam int READ_PAGES     = 4;
    localparam int READ_BYTES     = READ_PAGES * (PAGE_W / BYTE_W);

    localparam logic [7:0] OP_READ     = 8'h30;
    localparam logic [7:0] OP_WR_PAGE  = 8'hA2;
    localparam logic [7:0] OP_WR_COMPAT = 8'hA0;

    localparam logic [3:0] CODE_ACK = 4'hA;
    localparam logic [3:0] CODE_NAK = 4'h0;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_EXEC,
        ST_ANSWER,
        ST_STREAM
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [7:0]  opcode;
        logic [7:0]  addr;
        logic [31:0] word;
        logic [4:0]  cnt;
        logic [4:0]  need;
        logic [3:0]  code;
        logic [3:0]  idx;
    } seq_regs_t;
endpackage

// File: rtl/tpe_page_store.sv
module tpe_page_store
    import tpe_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter logic [NUM_PAGES*PAGE_W-1:0] INIT_IMAGE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_PAGES)-1:0] wr_page,
    input  logic [PAGE_W-1:0]            wr_word,
    input  logic                         pl_en,
    input  logic [$clog2(NUM_PAGES)-1:0] pl_page,
    input  logic [PAGE_W-1:0]            pl_word,
    input  logic [$clog2(NUM_PAGES)-1:0] rd_page,
    output logic [PAGE_W-1:0]            rd_word,
    output logic [NUM_PAGES-1:0]         lock_o
);
    localparam int ADDR_W = $clog2(NUM_PAGES);

    logic [PAGE_W-1:0] mem_q [NUM_PAGES];
    logic [PAGE_W-1:0] mem_d [NUM_PAGES];

    assign rd_word = mem_q[rd_page];

    // lock bit n sits at bit 16+n of the configuration page
    for (genvar n = 0; n < NUM_PAGES; n++) begin : g_lock
        if (n >= FIRST_LOCKABLE) begin : g_on
            assign lock_o[n] = mem_q[LOCK_PAGE][16+n];
        end else begin : g_off
            assign lock_o[n] = 1'b0;
        end
    end

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            if (wr_page == ADDR_W'(LOCK_PAGE)) begin
                mem_d[wr_page] = {mem_q[wr_page][31:16] | wr_word[31:16],
                                  mem_q[wr_page][15:0]};
            end else if (wr_page == ADDR_W'(OTP_PAGE)) begin
                mem_d[wr_page] = mem_q[wr_page] | wr_word;
            end else begin
                mem_d[wr_page] = wr_word;
            end
        end
        if (pl_en) begin
            mem_d[pl_page] = pl_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                mem_q[p] <= INIT_IMAGE[p*PAGE_W +: PAGE_W];
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // identifier pages move only through preload (R7)
    for (genvar n = 0; n < FIRST_WRITABLE; n++) begin : g_ro_chk
        assert_id_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(pl_en && pl_page == ADDR_W'(n)) |-> mem_q[n] == $past(mem_q[n]));
    end

    assert_otp_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pl_en && pl_page == ADDR_W'(OTP_PAGE))
        |-> ($past(mem_q[OTP_PAGE]) & ~mem_q[OTP_PAGE]) == '0);

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pl_en && pl_page == ADDR_W'(LOCK_PAGE))
        |-> ($past(lock_o) & ~lock_o) == '0);

    for (genvar n = FIRST_LOCKABLE; n < NUM_PAGES; n++) begin : g_lock_chk
        assert_locked_page_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(lock_o[n]) && !$past(pl_en && pl_page == ADDR_W'(n)))
            |-> mem_q[n] == $past(mem_q[n]));
    end
endmodule

// File: rtl/tpe_cmd_seq.sv
module tpe_cmd_seq
    import tpe_pkg::*;
#(
    parameter int NUM_PAGES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_byte,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [7:0]                   out_byte,
    output logic                         out_ack,
    output logic                         out_last,
    output logic                         wr_en,
    output logic [$clog2(NUM_PAGES)-1:0] wr_page,
    output logic [PAGE_W-1:0]            wr_word,
    output logic [$clog2(NUM_PAGES)-1:0] rd_page,
    input  logic [PAGE_W-1:0]            rd_word,
    input  logic [NUM_PAGES-1:0]         lock_i
);
    localparam int ADDR_W = $clog2(NUM_PAGES);
    localparam logic [7:0] ADDR_LIMIT = 8'(NUM_PAGES);
    localparam logic [3:0] LAST_IDX = 4'(READ_BYTES - 1);

    seq_regs_t q, d;
    logic      addr_ok;
    logic      permit;

    assign addr_ok = q.addr < ADDR_LIMIT;
    assign permit  = addr_ok
                  && (q.addr >= 8'(FIRST_WRITABLE))
                  && !(q.addr >= 8'(FIRST_LOCKABLE) && lock_i[q.addr[ADDR_W-1:0]]);

    assign wr_page = q.addr[ADDR_W-1:0];
    assign wr_word = q.word;
    assign rd_page = q.addr[ADDR_W-1:0] + ADDR_W'(q.idx[3:2]);

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_byte  = '0;
        out_ack   = 1'b0;
        out_last  = 1'b0;
        wr_en     = 1'b0;
        unique case (q.state)
            ST_OPCODE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.opcode = in_byte;
                    if (in_byte == OP_READ || in_byte == OP_WR_PAGE
                        || in_byte == OP_WR_COMPAT) begin
                        d.state = ST_ADDR;
                    end else begin
                        d.code  = CODE_NAK;
                        d.state = ST_ANSWER;
                    end
                end
            end
            ST_ADDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.addr = in_byte;
                    d.cnt  = '0;
                    d.word = '0;
                    d.idx  = '0;
                    if (q.opcode == OP_READ) begin
                        if (in_byte < ADDR_LIMIT) begin
                            d.state = ST_STREAM;
                        end else begin
                            d.code  = CODE_NAK;
                            d.state = ST_ANSWER;
                        end
                    end else begin
                        d.need  = (q.opcode == OP_WR_PAGE) ? 5'd4 : 5'd16;
                        d.state = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (q.cnt < 5'd4) begin
                        d.word[8*q.cnt[1:0] +: 8] = in_byte;
                    end
                    d.cnt = q.cnt + 5'd1;
                    if (q.cnt == q.need - 5'd1) begin
                        d.state = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                wr_en   = permit;
                d.code  = permit ? CODE_ACK : CODE_NAK;
                d.state = ST_ANSWER;
            end
            ST_ANSWER: begin
                out_valid = 1'b1;
                out_byte  = {4'h0, q.code};
                out_ack   = 1'b1;
                out_last  = 1'b1;
                if (out_ready) begin
                    d.state = ST_OPCODE;
                end
            end
            ST_STREAM: begin
                out_valid = 1'b1;
                out_byte  = rd_word[8*q.idx[1:0] +: 8];
                out_last  = (q.idx == LAST_IDX);
                if (out_ready) begin
                    d.idx = q.idx + 4'd1;
                    if (q.idx == LAST_IDX) begin
                        d.state = ST_OPCODE;
                    end
                end
            end
            default: d.state = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_OPCODE;
        end else begin
            q <= d;
        end
    end

    assert_no_id_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_page >= ADDR_W'(FIRST_WRITABLE));

    assert_write_hits_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !lock_i[wr_page]);

    assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack) |-> (out_byte == {4'h0, CODE_ACK} || out_byte == {4'h0, CODE_NAK}));

    assert_read_not_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STREAM) |-> !out_ack);
endmodule

// File: rtl/tag_page_engine.sv
module tag_page_engine
    import tpe_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter logic [NUM_PAGES*PAGE_W-1:0] INIT_IMAGE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_byte,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [7:0]                   out_byte,
    output logic                         out_ack,
    output logic                         out_last,
    input  logic                         pl_en,
    input  logic [$clog2(NUM_PAGES)-1:0] pl_page,
    input  logic [PAGE_W-1:0]            pl_word
);
    localparam int ADDR_W = $clog2(NUM_PAGES);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_page;
    logic [PAGE_W-1:0] wr_word;
    logic [ADDR_W-1:0] rd_page;
    logic [PAGE_W-1:0] rd_word;
    logic [NUM_PAGES-1:0] lock;

    tpe_cmd_seq #(.NUM_PAGES(NUM_PAGES)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_byte (out_byte),
        .out_ack  (out_ack),
        .out_last (out_last),
        .wr_en    (wr_en),
        .wr_page  (wr_page),
        .wr_word  (wr_word),
        .rd_page  (rd_page),
        .rd_word  (rd_word),
        .lock_i   (lock)
    );

    tpe_page_store #(.NUM_PAGES(NUM_PAGES), .INIT_IMAGE(INIT_IMAGE)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_page(wr_page),
        .wr_word(wr_word),
        .pl_en  (pl_en),
        .pl_page(pl_page),
        .pl_word(pl_word),
        .rd_page(rd_page),
        .rd_word(rd_word),
        .lock_o (lock)
    );

    assert_dir_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !pl_en)
        |=> (out_valid && $stable(out_byte) && $stable(out_ack) && $stable(out_last)));
endmodule

// File: tb/test_tag_page_engine.sv
module test_tag_page_engine;
    import tpe_pkg::*;

    function automatic logic [16*32-1:0] make_image();
        logic [16*32-1:0] img;
        for (int b = 0; b < 64; b++) begin
            img[b*8 +: 8] = 8'((b * 37 + 11) & 8'hFF);
        end
        img[2*32+16 +: 16] = 16'h0000; // no locks at power-on
        img[3*32 +: 32]    = 32'h0000_0001;
        return img;
    endfunction

    localparam logic [16*32-1:0] IMG = make_image();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_byte;
    logic       out_ack;
    logic       out_last;
    logic       pl_en = 1'b0;
    logic [3:0] pl_page = '0;
    logic [31:0] pl_word = '0;

    int errors = 0;
    int checks = 0;
    logic [31:0] ref_mem [16];

    always #2 clk = ~clk;

    tag_page_engine #(.NUM_PAGES(16), .INIT_IMAGE(IMG)) i_tag_page_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_ack(out_ack), .out_last(out_last),
        .pl_en(pl_en), .pl_page(pl_page), .pl_word(pl_word)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic ack, output logic last);
        int wait_n;
        wait_n = int'($urandom % 3);
        while (!out_valid) @(negedge clk);
        b = out_byte; ack = out_ack; last = out_last;
        for (int w = 0; w < wait_n; w++) @(negedge clk);
        if (wait_n > 0) begin
            // R13: byte held under back-pressure
            chk(out_valid && out_byte == b && out_last == last, "R13",
                {23'd0, out_valid, out_byte}, {24'd1, b});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic logic [7:0] ref_byte(input int start, input int i);
        logic [31:0] w;
        w = ref_mem[(start + i / 4) % 16];
        return w[8*(i%4) +: 8];
    endfunction

    task automatic model_write(input int addr, input logic [31:0] w, output logic [3:0] code);
        logic [15:0] lk;
        lk = ref_mem[2][31:16];
        if (addr > 15 || addr < 2) code = CODE_NAK;
        else if (addr >= 4 && lk[addr]) code = CODE_NAK;
        else begin
            code = CODE_ACK;
            if (addr == 2) ref_mem[2][31:16] = ref_mem[2][31:16] | w[31:16];
            else if (addr == 3) ref_mem[3] = ref_mem[3] | w;
            else ref_mem[addr] = w;
        end
    endtask

    task automatic expect_code(input logic [3:0] code, input string req);
        logic [7:0] b; logic a; logic l;
        recv_byte(b, a, l);
        chk(a && l && b == {4'h0, code}, req, {22'd0, a, l, b}, {22'd0, 2'b11, 4'h0, code});
    endtask

    task automatic do_read(input int addr, input string req);
        logic [7:0] b; logic a; logic l;
        int bad;
        send_byte(OP_READ);
        send_byte(8'(addr));
        if (addr > 15) begin
            expect_code(CODE_NAK, req);
        end else begin
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                recv_byte(b, a, l);
                if (b != ref_byte(addr, i) || a || (l != (i == 15))) begin
                    bad++;
                    chk(1'b0, req, {22'd0, a, l, b}, {23'd0, (i == 15), ref_byte(addr, i)});
                end
            end
            if (bad == 0) chk(1'b1, req, 0, 0);
        end
    endtask

    task automatic do_write(input logic [7:0] op, input int addr, input logic [31:0] w,
                            input string req);
        logic [3:0] code;
        int nb;
        nb = (op == OP_WR_PAGE) ? 4 : 16;
        send_byte(op);
        send_byte(8'(addr));
        for (int i = 0; i < nb; i++) begin
            if (i < 4) send_byte(w[8*i +: 8]);
            else send_byte(8'($urandom));
        end
        model_write(addr, w, code);
        expect_code(code, req);
    endtask

    task automatic do_preload(input int page, input logic [31:0] w);
        @(negedge clk);
        pl_en = 1'b1; pl_page = 4'(page); pl_word = w;
        @(negedge clk);
        pl_en = 1'b0;
        ref_mem[page] = w;
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        for (int p = 0; p < 16; p++) ref_mem[p] = IMG[p*32 +: 32];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 idle", {30'd0, in_ready, out_valid}, 32'd2);
        for (int a = 0; a < 16; a += 4) do_read(a, "R1 image / R2 read");

        do_read(14, "R3 wrap");
        do_read(16, "R4 read addr 0x10");
        do_write(OP_WR_PAGE, 18, 32'hDEAD_BEEF, "R4 write addr 0x12");
        do_write(OP_WR_COMPAT, 200, 32'h1111_2222, "R4 compat addr 200");
        do_read(0, "R4 unchanged");

        do_write(OP_WR_PAGE, 5, 32'hA1B2_C3D4, "R5 page write ack");
        do_read(5, "R5 readback");
        do_write(OP_WR_COMPAT, 6, 32'h5566_7788, "R6 compat ack");
        do_read(6, "R6 only 4 bytes stored");

        do_write(OP_WR_PAGE, 0, 32'hFFFF_FFFF, "R7 page 0 nak");
        do_write(OP_WR_COMPAT, 1, 32'hFFFF_FFFF, "R7 page 1 nak");
        do_read(0, "R7 id pages unchanged");

        do_write(OP_WR_PAGE, 3, 32'h0F0F_0000, "R8 otp ack");
        do_write(OP_WR_PAGE, 3, 32'h0000_00F0, "R8 otp ack 2");
        do_read(3, "R8 otp or");

        do_write(OP_WR_PAGE, 2, 32'h0010_ABCD, "R9 lock page 4");
        do_read(2, "R9 config bytes");
        do_write(OP_WR_PAGE, 4, 32'h1234_5678, "R10 locked nak");
        do_write(OP_WR_PAGE, 2, 32'h0000_0000, "R9 lock not cleared");
        do_write(OP_WR_COMPAT, 4, 32'h1234_5678, "R9/R10 still locked");
        do_write(OP_WR_PAGE, 7, 32'h0BAD_F00D, "R9 other page free");
        do_read(4, "R10 locked unchanged");

        send_byte(8'h55);
        expect_code(CODE_NAK, "R11 unknown opcode");
        do_read(8, "R11 next byte is opcode");

        do_preload(4, 32'hCAFE_0004);
        do_preload(3, 32'h0000_0000);
        do_preload(0, 32'h0102_0304);
        do_read(2, "R12 preload bypasses rules");
        do_preload(2, 32'h0000_0000);
        do_write(OP_WR_PAGE, 4, 32'h4444_4444, "R12 lock cleared by preload");
        do_read(3, "R12 readback");

        for (int it = 0; it < 300; it++) begin
            int kind, addr;
            logic [31:0] w;
            kind = int'($urandom % 8);
            addr = int'($urandom % 18);
            w    = $urandom;
            if (addr == 2 && ($urandom % 4) != 0) w[31:16] = 16'h0;
            case (kind)
                0, 1, 2: do_read(addr, "R2/R3 random read");
                3, 4: do_write(OP_WR_PAGE, addr, w, "R5/R7-R10 random write");
                5: do_write(OP_WR_COMPAT, addr, w, "R6 random compat");
                6: begin
                    if (addr == 2) w[31:16] = 16'h0;
                    do_preload(addr % 16, w);
                end
                default: begin
                    send_byte(8'h01 + 8'($urandom % 8'h20));
                    expect_code(CODE_NAK, "R11 random opcode");
                end
            endcase
        end
        for (int a = 0; a < 16; a += 4) do_read(a, "R2 final sweep");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule